// File: doc/BRIEF.md
# Stripmining Strip Sequencer

This block drives a long element-wise vector operation through hardware whose vector registers hold at most 64 elements. It takes an element count and three starting byte addresses. Two of the addresses are source operands and one is the result. It then hands out a series of strip descriptors. Each descriptor carries a strip length and the three base addresses that the strip must use.

The short leftover strip comes first. Its length is the count modulo 64. Every strip after it is exactly 64 elements long. After each accepted descriptor, the three addresses move forward by the strip length times the element size of 8 bytes, and the remaining count drops by the strip length.

Descriptors leave on a valid/ready handshake. A level done flag rises once every element has been handed out. A vector engine consumes the descriptors one at a time and performs the memory traffic and the arithmetic itself.

Top module: `strip_sequencer`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `desc_valid_o` and `done_o` are both low.
- R2: For a start with N not a multiple of 64, the first descriptor appears on the cycle after the start, with length N mod 64 (the low six bits of N).
- R3: When N is a nonzero multiple of 64, no zero-length strip is issued and the first length is 64. Every descriptor after the first has length 64.
- R4: Each accepted descriptor advances all three addresses by its length times 8. The first descriptor carries the start addresses unchanged, and addresses wrap modulo 2^32.
- R5: Exactly ceil(N/64) descriptors are issued and their lengths sum to N. On the cycle after the last handshake, `desc_valid_o` is low and `done_o` is high.
- R6: A start with N = 0 issues no descriptor and raises `done_o` on the next cycle.
- R7: While `desc_valid_o` is high and `desc_ready_i` is low, the length and all three addresses stay unchanged and valid stays high. State advances only on a cycle where valid and ready are both high.
- R8: A start pulse arriving while descriptors are still being issued has no effect on the descriptor stream.
- R9: An accepted start with nonzero N clears `done_o` on the next cycle. `done_o` then stays low until the final handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new sequence; accepted only when idle |
| n_i | input | 32 | Total element count (unsigned) |
| src_a_i | input | 32 | Start byte address of first source |
| src_b_i | input | 32 | Start byte address of second source |
| dst_i | input | 32 | Start byte address of destination |
| desc_valid_o | output | 1 | Strip descriptor available |
| desc_ready_i | input | 1 | Consumer accepts the descriptor |
| desc_len_o | output | 7 | Strip length, 1 to 64 |
| desc_src_a_o | output | 32 | First source address for this strip |
| desc_src_b_o | output | 32 | Second source address for this strip |
| desc_dst_o | output | 32 | Destination address for this strip |
| done_o | output | 1 | All elements issued (level, held until next start) |

## Verification
The in-RTL properties watch each cycle for several local rules. Under back-pressure, a descriptor must hold steady. Each accepted strip must move the address registers by length times 8 and cut the count by the length. A strip that is not the last must be followed by a 64-element strip. The final strip must leave the block idle with done set. A start while busy must leave the count untouched, and a zero count must go straight to done.

Some properties span a whole sequence and only the bench's scenarios can show them. The bench checks the remainder-first order, the total strip count, address wrap past 2^32, clearing of done by a fresh start, and behaviour across a mid-sequence reset.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned DEF_CNT_W  = 32;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_MAX_VL = 64;
  localparam int unsigned DEF_ELEM_B = 8;
endpackage

// File: rtl/strip_len_calc.sv
// Current strip length from the remaining count. Because the leftover strip
// goes first, the remaining count is a multiple of MAX_VL after it, so the
// low bits alone pick the length.
module strip_len_calc #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned LOW_W = $clog2(MAX_VL),
  localparam int unsigned VL_W  = LOW_W + 1
) (
  input  logic [CNT_W-1:0] remaining_i,
  output logic [VL_W-1:0]  len_o
);
  logic [LOW_W-1:0] low_bits;

  always_comb begin
    low_bits = remaining_i[LOW_W-1:0];
    if (low_bits != '0) len_o = {1'b0, low_bits};
    else                len_o = VL_W'(MAX_VL);
  end
endmodule

// File: rtl/strip_ptr_reg.sv
// One address register: loaded at start, stepped by len * ELEM_B on handshake.
module strip_ptr_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MAX_VL = 64,
  parameter int unsigned ELEM_B = 8,
  localparam int unsigned VL_W  = $clog2(MAX_VL) + 1,
  localparam int unsigned SHIFT = $clog2(ELEM_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_i,
  input  logic [VL_W-1:0]   len_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, step;
  logic              ptr_en;

  always_comb begin
    step   = ADDR_W'(len_i) << SHIFT;
    ptr_en = load_i | adv_i;
    ptr_d  = load_i ? start_addr_i : (ptr_q + step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> ptr_q == $past(ptr_q) + (ADDR_W'($past(len_i)) << SHIFT))
    else $error("R4 address step wrong");

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(ptr_q))
    else $error("R7 address moved without handshake");
endmodule

// File: rtl/strip_ctrl.sv
// Sequence state, remaining count and done flag.
module strip_ctrl
  import strip_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned VL_W  = $clog2(MAX_VL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             ready_i,
  input  logic [VL_W-1:0]  len_i,
  output logic [CNT_W-1:0] remaining_o,
  output logic             valid_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             done_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d, len_ext;
  logic             rem_en;
  logic             done_q, done_d;
  logic             fire, last;

  always_comb begin
    len_ext = CNT_W'(len_i);
    fire    = (state_q == SEQ_RUN) && ready_i;
    last    = (rem_q == len_ext);
    state_d = state_q;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    done_d  = done_q;
    load_o  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          if (n_i == '0) begin
            done_d = 1'b1;
          end else begin
            done_d  = 1'b0;
            rem_d   = n_i;
            rem_en  = 1'b1;
            load_o  = 1'b1;
            state_d = SEQ_RUN;
          end
        end
      end
      SEQ_RUN: begin
        if (fire) begin
          rem_d  = rem_q - len_ext;
          rem_en = 1'b1;
          if (last) begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign valid_o     = (state_q == SEQ_RUN);
  assign adv_o       = fire;
  assign done_o      = done_q;
  assign remaining_o = rem_q;

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && rem_q != CNT_W'(len_i)) |=>
      valid_o && rem_q == $past(rem_q) - CNT_W'($past(len_i)))
    else $error("R5 remaining count step wrong");

  p_full_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && rem_q != CNT_W'(len_i)) |=> len_i == VL_W'(MAX_VL))
    else $error("R3 later strip not full length");

  p_last_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && rem_q == CNT_W'(len_i)) |=> !valid_o && done_o)
    else $error("R5 sequence did not end after last strip");

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o)
    else $error("R5 valid while done");

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && start_i) |=> valid_o && $stable(rem_q))
    else $error("R8 start disturbed running sequence");

  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i && n_i == '0) |=> !valid_o && done_o)
    else $error("R6 zero count not handled");
endmodule

// File: rtl/strip_sequencer.sv
module strip_sequencer #(
  parameter int unsigned CNT_W  = strip_pkg::DEF_CNT_W,
  parameter int unsigned ADDR_W = strip_pkg::DEF_ADDR_W,
  parameter int unsigned MAX_VL = strip_pkg::DEF_MAX_VL,
  parameter int unsigned ELEM_B = strip_pkg::DEF_ELEM_B,
  localparam int unsigned LOW_W = $clog2(MAX_VL),
  localparam int unsigned VL_W  = LOW_W + 1,
  localparam int unsigned N_PTR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  n_i,
  input  logic [ADDR_W-1:0] src_a_i,
  input  logic [ADDR_W-1:0] src_b_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [VL_W-1:0]   desc_len_o,
  output logic [ADDR_W-1:0] desc_src_a_o,
  output logic [ADDR_W-1:0] desc_src_b_o,
  output logic [ADDR_W-1:0] desc_dst_o,
  output logic              done_o
);
  logic [CNT_W-1:0]  remaining;
  logic [VL_W-1:0]   len;
  logic              load, adv;
  logic [ADDR_W-1:0] start_addr [N_PTR];
  logic [ADDR_W-1:0] cur_addr   [N_PTR];

  assign start_addr[0] = src_a_i;
  assign start_addr[1] = src_b_i;
  assign start_addr[2] = dst_i;

  strip_ctrl #(.CNT_W(CNT_W), .MAX_VL(MAX_VL)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .n_i         (n_i),
    .ready_i     (desc_ready_i),
    .len_i       (len),
    .remaining_o (remaining),
    .valid_o     (desc_valid_o),
    .load_o      (load),
    .adv_o       (adv),
    .done_o      (done_o)
  );

  strip_len_calc #(.CNT_W(CNT_W), .MAX_VL(MAX_VL)) u_len (
    .remaining_i (remaining),
    .len_o       (len)
  );

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    strip_ptr_reg #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .ELEM_B(ELEM_B)) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .start_addr_i (start_addr[g]),
      .adv_i        (adv),
      .len_i        (len),
      .ptr_o        (cur_addr[g])
    );
  end

  assign desc_len_o   = len;
  assign desc_src_a_o = cur_addr[0];
  assign desc_src_b_o = cur_addr[1];
  assign desc_dst_o   = cur_addr[2];

  p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o |-> (desc_len_o != '0 && desc_len_o <= VL_W'(MAX_VL)))
    else $error("R3 strip length out of range");

  p_first_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !desc_valid_o && n_i[LOW_W-1:0] != '0) |=>
      desc_valid_o && desc_len_o == {1'b0, $past(n_i[LOW_W-1:0])})
    else $error("R2 first strip length wrong");

  p_desc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && !desc_ready_i) |=>
      desc_valid_o && $stable(desc_len_o) && $stable(desc_src_a_o) &&
      $stable(desc_src_b_o) && $stable(desc_dst_o))
    else $error("R7 descriptor changed under back-pressure");
endmodule

// File: tb/tb_strip_sequencer.sv
module tb_strip_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] n_i, src_a_i, src_b_i, dst_i;
  logic        desc_valid_o, desc_ready_i, done_o;
  logic [6:0]  desc_len_o;
  logic [31:0] desc_src_a_o, desc_src_b_o, desc_dst_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  strip_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(n_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .desc_valid_o(desc_valid_o), .desc_ready_i(desc_ready_i),
    .desc_len_o(desc_len_o), .desc_src_a_o(desc_src_a_o),
    .desc_src_b_o(desc_src_b_o), .desc_dst_o(desc_dst_o), .done_o(done_o)
  );

  // {stall, intrude, n, a, b, d}
  localparam int NV = 7;
  localparam logic [129:0] VECS [NV] = '{
    {1'b0, 1'b0, 32'd5,   32'h0000_1000, 32'h0000_2000, 32'h0000_3000},
    {1'b0, 1'b0, 32'd64,  32'h0000_0100, 32'h0000_0800, 32'h0001_0000},
    {1'b1, 1'b0, 32'd130, 32'h1000_0000, 32'h2000_0000, 32'h3000_0000},
    {1'b1, 1'b1, 32'd200, 32'h0000_4000, 32'h0000_8000, 32'h0000_C000},
    {1'b0, 1'b0, 32'd128, 32'hFFFF_FFF0, 32'hFFFF_FF00, 32'h0000_0040},
    {1'b0, 1'b0, 32'd1,   32'h0000_0008, 32'h0000_0010, 32'h0000_0018},
    {1'b1, 1'b0, 32'd63,  32'h0000_0200, 32'h0000_0400, 32'h0000_0600}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      summary();
    end
  end

  task automatic run_vec(input logic [129:0] v);
    bit          stall   = v[129];
    bit          intrude = v[128];
    logic [31:0] n = v[127:96], a = v[95:64], b = v[63:32], d = v[31:0];
    int          idx = 0, cyc = 0, exp_cnt;
    logic [31:0] sum = 0;
    bit          held = 0, poked = 0;
    logic [6:0]  s_len;
    logic [31:0] s_a, s_b, s_d;
    exp_cnt = (n + 63) / 64;
    @(negedge clk);
    start_i = 1; n_i = n; src_a_i = a; src_b_i = b; dst_i = d; desc_ready_i = 0;
    @(negedge clk);
    start_i = 0;
    chk(done_o == 0, "R9", "done after start", done_o, 0);
    while (!done_o && cyc < 2000) begin
      bit rdy = stall ? (cyc % 3 != 1) : 1'b1;
      start_i = 0;
      if (held) begin
        chk(desc_valid_o && desc_len_o == s_len && desc_src_a_o == s_a &&
            desc_src_b_o == s_b && desc_dst_o == s_d, "R7", "held descriptor",
            {25'd0, desc_len_o}, {25'd0, s_len});
        held = 0;
      end
      if (intrude && idx == 1 && !poked) begin
        start_i = 1; n_i = 32'd7; src_a_i = 32'hDEAD_0000; poked = 1; // R8
      end
      if (desc_valid_o) begin
        if (!rdy) begin
          held = 1; s_len = desc_len_o; s_a = desc_src_a_o;
          s_b = desc_src_b_o; s_d = desc_dst_o;
        end else begin
          logic [6:0] el = (idx == 0 && n[5:0] != 0) ? {1'b0, n[5:0]} : 7'd64;
          chk(desc_len_o == el, (idx == 0 && n[5:0] != 0) ? "R2" : "R3",
              $sformatf("len strip %0d", idx), {25'd0, desc_len_o}, {25'd0, el});
          chk(desc_src_a_o == a + sum * 8 && desc_src_b_o == b + sum * 8 &&
              desc_dst_o == d + sum * 8, intrude ? "R8" : "R4",
              $sformatf("addr strip %0d", idx), desc_src_a_o, a + sum * 8);
          sum += el;
          idx++;
        end
      end
      desc_ready_i = rdy;
      @(negedge clk);
      cyc++;
    end
    start_i = 0;
    desc_ready_i = 0;
    chk(done_o && !desc_valid_o, "R5", "done at end", {31'd0, done_o}, 1);
    chk(idx == exp_cnt, "R5", "strip count", idx, exp_cnt);
    chk(sum == n, "R5", "length total", sum, n);
  endtask

  initial begin
    rst_n = 0; start_i = 0; n_i = 0; src_a_i = 0; src_b_i = 0; dst_i = 0;
    desc_ready_i = 0;
    repeat (2) @(negedge clk);
    chk(!desc_valid_o && !done_o, "R1", "in reset", {desc_valid_o, done_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!desc_valid_o && !done_o, "R1", "after release", {desc_valid_o, done_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: zero count
    @(negedge clk);
    start_i = 1; n_i = 0; desc_ready_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(done_o && !desc_valid_o, "R6", "zero count done", {desc_valid_o, done_o}, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!desc_valid_o, "R6", "no descriptor", desc_valid_o, 0);
    end
    desc_ready_i = 0;

    // R9 again after zero-count done, then mid-sequence reset (R1)
    run_vec({1'b0, 1'b0, 32'd70, 32'h0, 32'h100, 32'h200});
    @(negedge clk);
    start_i = 1; n_i = 32'd300;
    @(negedge clk);
    start_i = 0; desc_ready_i = 1;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(!desc_valid_o && !done_o, "R1", "mid-run reset", {desc_valid_o, done_o}, 0);
    @(negedge clk);
    rst_n = 1; desc_ready_i = 0;
    repeat (2) @(negedge clk);
    chk(!desc_valid_o && !done_o, "R1", "idle after reset", {desc_valid_o, done_o}, 0);

    summary();
  end
endmodule